// File: doc/BRIEF.md
# Quad-I/O Serial Flash Read Engine with Prefetch Window

This block answers word reads from a host memory port by fetching bytes from an external serial NOR flash over four bidirectional data lines. It uses the quad-I/O fast read command. The command byte goes out only on the first transaction after reset or after an abort. That transaction ends with a continuous-read mode byte, so every later transaction opens directly with the address.

Each flash transaction fills a local window of `BUF_BYTES` bytes, starting at the address that missed. A host read that falls inside this window is answered from the window. If the bytes it needs have not arrived yet, the read waits for them. A read outside the window ends the current transaction and starts a new one. A deselect timer makes sure chip select stays high for a minimum number of system clocks between two transactions. An abort input ends any transaction at once and forces the next one to resend the command.

Top module: `qspi_xip_reader`

## Requirements
- R1: After reset `cs_n_o` is 1, `sck_o` is 0, `io_oe_o` is 0, `rsp_valid_o` is 0 and `req_ready_o` is 1. Whenever `cs_n_o` is 1, `sck_o` is 0 and `io_oe_o` is 0.
- R2: The first transaction after reset sends opcode 0xEB on `io_o[0]` over 8 SCK cycles, MSB first, with `io_oe_o` = 4'b0001.
- R3: Every transaction then sends the 24-bit address on `io_o[3:0]` in 6 SCK cycles, most significant nibble first. Next it sends the mode byte 0xA0 in 2 SCK cycles, high nibble first. `io_oe_o` is 4'b1111 in both phases.
- R4: Once a mode byte has been sent and no abort has followed, a transaction carries no opcode: its first SCK cycle is already an address nibble.
- R5: After the mode byte, `DUMMY_CYC` SCK cycles pass with `io_oe_o` = 0. Data nibbles are then sampled on the rising SCK edge, high nibble first. The response word holds the bytes at addresses A..A+3 of request address A, with the byte at A in bits 7:0.
- R6: A transaction that is not cut short clocks in exactly `BUF_BYTES` bytes (64 nibbles by default) and then raises `cs_n_o`.
- R7: A request at offset 0..`BUF_BYTES`-4 from the window start, with its bytes already fetched, is answered in the second cycle after acceptance with no chip-select activity. Offset `BUF_BYTES`-3 or more is a miss and starts a transaction at the requested address.
- R8: A miss while a prefetch is running ends that transaction early and starts a new one at the new address.
- R9: Between two transactions `cs_n_o` stays high for at least `CSH_CYC` system cycles. A restart that is waiting on a miss lowers it after exactly `CSH_CYC` cycles.
- R10: `abort_i` raises `cs_n_o` by the next cycle and invalidates the window. The next transaction resends opcode 0xEB.
- R11: Each SCK high phase and each SCK low phase lasts `HALF_DIV` system cycles. The resulting SCK rate, `SYS_CLK_MHZ`/(2·`HALF_DIV`), must not exceed 108 MHz.
- R12: One request is outstanding at a time. `req_ready_o` is 0 while it is pending, responses come in request order, and `rsp_valid_o` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Host read request valid |
| req_addr_i | input | 24 | Host byte address |
| req_ready_o | output | 1 | Request accepted when high with valid |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_data_o | output | 32 | Little-endian response word |
| abort_i | input | 1 | Ends any transaction and drops continuous mode |
| sck_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | 1 | Flash chip select, active low |
| io_o | output | 4 | Data lines driven toward the flash |
| io_oe_o | output | 4 | Per-line output enable |
| io_i | input | 4 | Data lines sampled from the flash |

## Verification
A wrong window base or fill count shows up within a few cycles of the next request. It appears either as a wrong response word or as a chip-select pulse where a hit was due, or as a missing pulse where a miss was due. A stale continuous-mode flag changes the first SCK cycle of the next transaction: an opcode appears where an address nibble was due, or the reverse. The flash model decodes this, so the address it records is wrong. Deselect-timer faults show as a chip-select high interval that differs from `CSH_CYC` on an immediate restart. Divider faults show as SCK phases longer or shorter than `HALF_DIV` within the first serial cycle.

// File: rtl/qspi_xip_pkg.sv
package qspi_xip_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_ADDR,
      ST_MODE,
      ST_DUMMY,
      ST_DATA
   } qx_state_e;

   localparam logic [7:0] QX_OPCODE    = 8'hEB;
   localparam logic [7:0] QX_MODE_BYTE = 8'hA0;
   localparam int         QX_CMD_BITS  = 8;

endpackage

// File: rtl/qspi_xip_sckgen.sv
module qspi_xip_sckgen #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic clear_i,
   output logic sck_o,
   output logic rise_o,
   output logic fall_o
);

   logic sck_q;
   logic tick;

   generate
      if (HALF_DIV == 1) begin : g_fast
         assign tick = run_i;
      end else begin : g_div
         localparam int DW = $clog2(HALF_DIV);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !run_i || clear_i) div_q <= '0;
            else if (div_q == DW'(HALF_DIV - 1)) div_q <= '0;
            else div_q <= div_q + 1'b1;
         end
         assign tick = run_i && (div_q == DW'(HALF_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i || clear_i) sck_q <= 1'b0;
      else if (tick) sck_q <= ~sck_q;
   end

   assign sck_o  = sck_q;
   assign rise_o = tick && !sck_q;
   assign fall_o = tick && sck_q;

endmodule

// File: rtl/qspi_xip_csgap.sv
module qspi_xip_csgap #(
   parameter int CSH_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   output logic ok_o
);

   localparam int GW = $clog2(CSH_CYC + 1);
   logic [GW-1:0] gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) gap_q <= GW'(CSH_CYC);
      else if (!cs_n_i) gap_q <= '0;
      else if (gap_q < GW'(CSH_CYC)) gap_q <= gap_q + 1'b1;
   end

   assign ok_o = cs_n_i && (gap_q >= GW'(CSH_CYC - 1));

endmodule

// File: rtl/qspi_xip_pfbuf.sv
module qspi_xip_pfbuf #(
   parameter int BUF_BYTES = 32,
   localparam int OW = $clog2(BUF_BYTES),
   localparam int FW = $clog2(BUF_BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          wr_i,
   input  logic [7:0]    wr_byte_i,
   input  logic [OW-1:0] rd_off_i,
   output logic [FW-1:0] fill_o,
   output logic          full_o,
   output logic [31:0]   rd_word_o
);

   logic [7:0]    mem_q [BUF_BYTES];
   logic [FW-1:0] fill_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) fill_q <= '0;
      else if (wr_i) fill_q <= fill_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_i && !clr_i) mem_q[fill_q[OW-1:0]] <= wr_byte_i;
   end

   for (genvar g = 0; g < 4; g++) begin : g_lane
      logic [OW-1:0] idx;
      assign idx = rd_off_i + OW'(g);
      assign rd_word_o[8*g +: 8] = mem_q[idx];
   end

   assign fill_o = fill_q;
   assign full_o = (fill_q == FW'(BUF_BYTES));

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= FW'(BUF_BYTES))
      else $error("window fill count passed its size");

endmodule

// File: rtl/qspi_xip_reader.sv
module qspi_xip_reader
   import qspi_xip_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int BUF_BYTES   = 32,
   parameter int HALF_DIV    = 2,
   parameter int DUMMY_CYC   = 4,
   parameter int CSH_CYC     = 2,
   parameter int SYS_CLK_MHZ = 100,
   parameter int SCK_MAX_MHZ = 108
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   output logic              req_ready_o,
   output logic              rsp_valid_o,
   output logic [31:0]       rsp_data_o,
   input  logic              abort_i,
   output logic              sck_o,
   output logic              cs_n_o,
   output logic [3:0]        io_o,
   output logic [3:0]        io_oe_o,
   input  logic [3:0]        io_i
);

   localparam int ADDR_NIBS = ADDR_W / 4;
   localparam int OW        = $clog2(BUF_BYTES);
   localparam int FW        = $clog2(BUF_BYTES + 1);
   localparam int PH_A      = (QX_CMD_BITS > ADDR_NIBS) ? QX_CMD_BITS : ADDR_NIBS;
   localparam int PH_MAX    = (PH_A > DUMMY_CYC) ? PH_A : DUMMY_CYC;
   localparam int CW        = $clog2(PH_MAX + 1);
   localparam int HW        = $clog2(CSH_CYC + 1);

   initial begin
      assert (ADDR_W % 4 == 0) else $error("ADDR_W must be whole nibbles");
      assert (BUF_BYTES >= 8 && (BUF_BYTES & (BUF_BYTES - 1)) == 0)
         else $error("BUF_BYTES must be a power of two of at least 8");
      assert (HALF_DIV >= 1) else $error("HALF_DIV must be at least 1");
      assert (DUMMY_CYC >= 1) else $error("DUMMY_CYC must be at least 1");
      assert (CSH_CYC >= 1) else $error("CSH_CYC must be at least 1");
      assert (SYS_CLK_MHZ <= 2 * HALF_DIV * SCK_MAX_MHZ)
         else $error("serial clock above its limit");
   end

   qx_state_e         st_q;
   logic [CW-1:0]     ph_cnt_q, ph_last;
   logic              active_q, cs_n_q, cont_q, win_v_q, nib_ph_q;
   logic [3:0]        nib_hi_q;
   logic [ADDR_W-1:0] base_q, pend_addr_q, off;
   logic              pend_v_q, rsp_v_q;
   logic [31:0]       rsp_d_q, rd_word;
   logic              rise, fall, gap_ok, buf_full;
   logic [FW-1:0]     fill;
   logic [FW:0]       need_fill;
   logic              in_win, have, hit_go, need_start, fin_now, stop_now, start_now;
   logic              wr_en, buf_clr, ph_done;

   // ---------------- window hit / miss ----------------
   assign off        = pend_addr_q - base_q;
   assign in_win     = win_v_q && (off <= ADDR_W'(BUF_BYTES - 4));
   assign need_fill  = (FW+1)'(off[OW-1:0]) + (FW+1)'(4);
   assign have       = (FW+1)'(fill) >= need_fill;
   assign hit_go     = pend_v_q && in_win && have;
   assign need_start = pend_v_q && !in_win;

   assign fin_now   = active_q && (st_q == ST_DATA) && fall && buf_full;
   assign stop_now  = active_q && (abort_i || need_start || fin_now);
   assign start_now = !active_q && need_start && gap_ok && !abort_i;
   assign wr_en     = active_q && (st_q == ST_DATA) && rise && nib_ph_q && !buf_full;
   assign buf_clr   = start_now || abort_i;

   always_comb begin
      case (st_q)
         ST_CMD:   ph_last = CW'(QX_CMD_BITS - 1);
         ST_ADDR:  ph_last = CW'(ADDR_NIBS - 1);
         ST_MODE:  ph_last = CW'(1);
         ST_DUMMY: ph_last = CW'(DUMMY_CYC - 1);
         default:  ph_last = '0;
      endcase
   end
   assign ph_done = fall && (ph_cnt_q == ph_last);

   // ---------------- serial sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         ph_cnt_q <= '0;
         active_q <= 1'b0;
         cs_n_q   <= 1'b1;
         cont_q   <= 1'b0;
         win_v_q  <= 1'b0;
         nib_ph_q <= 1'b0;
         nib_hi_q <= '0;
         base_q   <= '0;
      end else begin
         if (stop_now) begin
            active_q <= 1'b0;
            cs_n_q   <= 1'b1;
            st_q     <= ST_IDLE;
         end else if (start_now) begin
            active_q <= 1'b1;
            cs_n_q   <= 1'b0;
            st_q     <= cont_q ? ST_ADDR : ST_CMD;
            ph_cnt_q <= '0;
            base_q   <= pend_addr_q;
            win_v_q  <= 1'b1;
            nib_ph_q <= 1'b0;
         end else if (active_q) begin
            if (st_q == ST_DATA) begin
               if (rise) begin
                  if (!nib_ph_q) nib_hi_q <= io_i;
                  nib_ph_q <= ~nib_ph_q;
               end
            end else if (ph_done) begin
               ph_cnt_q <= '0;
               case (st_q)
                  ST_CMD:  st_q <= ST_ADDR;
                  ST_ADDR: st_q <= ST_MODE;
                  ST_MODE: begin
                     st_q   <= ST_DUMMY;
                     cont_q <= 1'b1;
                  end
                  default: st_q <= ST_DATA;
               endcase
            end else if (fall) begin
               ph_cnt_q <= ph_cnt_q + 1'b1;
            end
         end
         if (abort_i) begin
            cont_q  <= 1'b0;
            win_v_q <= 1'b0;
         end
      end
   end

   // ---------------- host side ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v_q    <= 1'b0;
         pend_addr_q <= '0;
         rsp_v_q     <= 1'b0;
         rsp_d_q     <= '0;
      end else begin
         rsp_v_q <= 1'b0;
         if (hit_go) begin
            rsp_v_q  <= 1'b1;
            rsp_d_q  <= rd_word;
            pend_v_q <= 1'b0;
         end else if (req_valid_i && !pend_v_q) begin
            pend_v_q    <= 1'b1;
            pend_addr_q <= req_addr_i;
         end
      end
   end

   // ---------------- pin drive ----------------
   always_comb begin
      io_o    = '0;
      io_oe_o = '0;
      if (active_q) begin
         case (st_q)
            ST_CMD: begin
               io_oe_o = 4'b0001;
               io_o[0] = QX_OPCODE[3'(QX_CMD_BITS - 1 - int'(ph_cnt_q))];
            end
            ST_ADDR: begin
               io_oe_o = 4'b1111;
               io_o    = base_q[4*(ADDR_NIBS - 1 - int'(ph_cnt_q)) +: 4];
            end
            ST_MODE: begin
               io_oe_o = 4'b1111;
               io_o    = (ph_cnt_q == '0) ? QX_MODE_BYTE[7:4] : QX_MODE_BYTE[3:0];
            end
            default: ;
         endcase
      end
   end

   qspi_xip_sckgen #(.HALF_DIV(HALF_DIV)) u_sck (
      .clk(clk), .rst_n(rst_n), .run_i(active_q), .clear_i(stop_now),
      .sck_o(sck_o), .rise_o(rise), .fall_o(fall)
   );

   qspi_xip_csgap #(.CSH_CYC(CSH_CYC)) u_gap (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_q), .ok_o(gap_ok)
   );

   qspi_xip_pfbuf #(.BUF_BYTES(BUF_BYTES)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .wr_i(wr_en),
      .wr_byte_i({nib_hi_q, io_i}), .rd_off_i(off[OW-1:0]),
      .fill_o(fill), .full_o(buf_full), .rd_word_o(rd_word)
   );

   assign cs_n_o      = cs_n_q;
   assign req_ready_o = !pend_v_q;
   assign rsp_valid_o = rsp_v_q;
   assign rsp_data_o  = rsp_d_q;

   // ---------------- assertions ----------------
   logic [HW-1:0] hi_run_q;
   always_ff @(posedge clk) begin
      if (!rst_n) hi_run_q <= HW'(CSH_CYC);
      else if (!cs_n_o) hi_run_q <= '0;
      else if (hi_run_q < HW'(CSH_CYC)) hi_run_q <= hi_run_q + 1'b1;
   end

   p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> (!sck_o && io_oe_o == 4'b0000))
      else $error("bus active while deselected");

   p_full_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_o && buf_full && fall) |=> cs_n_o)
      else $error("clocking continued past a full window");

   p_csh_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> (hi_run_q >= HW'(CSH_CYC)))
      else $error("chip select high time too short");

   p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> cs_n_o)
      else $error("abort did not release chip select");

   p_rsp_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |=> !rsp_valid_o)
      else $error("response strobe held");

endmodule

// File: tb/tb_qspi_xip_reader.sv
module tb_qspi_xip_reader;

   localparam int HALF = 2, DUM = 4, CSH = 2, BUFB = 32, SYS_MHZ = 100;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req_valid = 1'b0, abort = 1'b0;
   logic [23:0] req_addr = '0;
   logic        req_ready, rsp_valid, sck, cs_n;
   logic [31:0] rsp_data;
   logic [3:0]  io_out, io_oe;
   logic [3:0]  flash_io = '0;

   always #5 clk = ~clk;

   qspi_xip_reader #(.BUF_BYTES(BUFB), .HALF_DIV(HALF), .DUMMY_CYC(DUM),
                     .CSH_CYC(CSH), .SYS_CLK_MHZ(SYS_MHZ)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
      .req_ready_o(req_ready), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
      .abort_i(abort), .sck_o(sck), .cs_n_o(cs_n), .io_o(io_out),
      .io_oe_o(io_oe), .io_i(flash_io)
   );

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] fmem(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3C;
   endfunction

   function automatic logic [31:0] fword(input logic [23:0] a);
      return {fmem(a + 24'd3), fmem(a + 24'd2), fmem(a + 24'd1), fmem(a)};
   endfunction

   // ---------------- flash model ----------------
   int          m_clk = 0, m_oe_bad = 0, m_txns = 0, last_nibs = 0;
   bit          m_cmd = 1'b0;
   logic [7:0]  m_op = '0, m_mode = '0;
   logic [23:0] m_addr = '0;

   function automatic int m_pre();
      return (m_cmd ? 8 : 0) + 6 + 2 + DUM;
   endfunction

   always @(negedge cs_n) begin
      m_clk = 0; m_oe_bad = 0; m_cmd = 1'b0; m_txns++;
   end

   always @(posedge cs_n) last_nibs = m_clk - m_pre();

   always @(posedge sck) if (!cs_n) begin
      m_clk++;
      if (m_clk == 1) m_cmd = (io_oe == 4'b0001);
      if (m_clk <= (m_cmd ? 8 : 0)) m_op = {m_op[6:0], io_out[0]};
      else if (m_clk <= (m_cmd ? 8 : 0) + 6) m_addr = {m_addr[19:0], io_out};
      else if (m_clk <= (m_cmd ? 8 : 0) + 8) m_mode = {m_mode[3:0], io_out};
      else if (io_oe != 4'b0000) m_oe_bad++;
   end

   always @(negedge sck) if (!cs_n && m_clk >= m_pre()) begin
      int k;
      logic [7:0] b;
      k = m_clk - m_pre();
      b = fmem(m_addr + 24'(k / 2));
      flash_io = (k % 2 == 0) ? b[7:4] : b[3:0];
   end

   // ---------------- monitors ----------------
   int cyc = 0, hi_run = 1000, min_gap = 1000, cs_low_cnt = 0, sck_bad = 0, ph_len = 0;
   logic prev_cs = 1'b1, prev_sck = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (cs_n) hi_run++;
         else begin
            if (prev_cs && hi_run < min_gap) min_gap = hi_run;
            hi_run = 0;
            cs_low_cnt++;
         end
         if (!cs_n && !prev_cs) begin
            if (sck != prev_sck) begin
               if (ph_len != HALF) sck_bad++;
               ph_len = 1;
            end else ph_len++;
         end else ph_len = cs_n ? 0 : 1;
      end
      prev_cs = cs_n; prev_sck = sck;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic do_read(input logic [23:0] a, output logic [31:0] d, output int lat, output bit rdy_low);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      rdy_low = !req_ready;
      lat = 1;
      while (!rsp_valid && lat < 5000) begin @(negedge clk); lat++; end
      d = rsp_data;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1 && sck == 1'b0 && io_oe == 4'b0 && rsp_valid == 1'b0,
          "R1 reset pins", {cs_n, sck, io_oe, rsp_valid}, {1'b1, 1'b0, 4'b0, 1'b0});
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
   endtask

   task automatic t_first();
      logic [31:0] d; int lat; bit rl;
      do_read(24'h001000, d, lat, rl);
      chk(rl, "R12 ready low while pending", !rl, 0);
      chk(d == fword(24'h001000), "R5 first word", d, fword(24'h001000));
      chk(m_cmd && m_op == 8'hEB, "R2 opcode sent", m_op, 8'hEB);
      chk(m_addr == 24'h001000, "R3 address nibbles", m_addr, 24'h001000);
      chk(m_mode == 8'hA0, "R3 mode byte", m_mode, 8'hA0);
      chk(m_oe_bad == 0, "R5 lines released after mode", m_oe_bad, 0);
      repeat (400) @(negedge clk);
      chk(cs_n == 1'b1 && last_nibs == 2 * BUFB, "R6 full window nibbles", last_nibs, 2 * BUFB);
   endtask

   task automatic t_hit();
      logic [31:0] d; int lat; bit rl; int base_low;
      base_low = cs_low_cnt;
      do_read(24'h001004, d, lat, rl);
      chk(d == fword(24'h001004) && lat == 2, "R7 hit word and latency", {d[23:0], 8'(lat)}, {fword(24'h001004), 8'd2});
      do_read(24'h00101C, d, lat, rl);
      chk(d == fword(24'h00101C), "R7 hit at last offset", d, fword(24'h00101C));
      chk(cs_low_cnt == base_low, "R7 no chip select on hits", cs_low_cnt, base_low);
   endtask

   task automatic t_edge();
      logic [31:0] d; int lat; bit rl; int tx0;
      tx0 = m_txns;
      do_read(24'h00101D, d, lat, rl);
      chk(m_txns == tx0 + 1 && m_addr == 24'h00101D, "R7 offset past window misses", m_addr, 24'h00101D);
      chk(!m_cmd, "R4 no opcode in continuous mode", m_cmd, 0);
      chk(d == fword(24'h00101D), "R5 unaligned word", d, fword(24'h00101D));
   endtask

   task automatic t_miss_mid();
      logic [31:0] d; int lat; bit rl;
      do_read(24'h003000, d, lat, rl);
      chk(d == fword(24'h003000), "R8 first word", d, fword(24'h003000));
      do_read(24'h005000, d, lat, rl);
      chk(d == fword(24'h005000) && m_addr == 24'h005000, "R8 restart address", m_addr, 24'h005000);
      chk(last_nibs < 2 * BUFB, "R8 prefetch cut short", last_nibs, 2 * BUFB - 1);
      chk(min_gap == CSH, "R9 restart gap", min_gap, CSH);
   endtask

   task automatic t_abort();
      logic [31:0] d; int lat; bit rl;
      do_read(24'h006000, d, lat, rl);
      repeat (6) @(negedge clk);
      chk(cs_n == 1'b0, "R10 prefetch running before abort", cs_n, 0);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(cs_n == 1'b1, "R10 chip select released", cs_n, 1);
      do_read(24'h006008, d, lat, rl);
      chk(m_cmd && m_op == 8'hEB, "R10 opcode resent", m_op, 8'hEB);
      chk(d == fword(24'h006008), "R10 word after abort", d, fword(24'h006008));
   endtask

   task automatic t_order();
      logic [31:0] d1, d2; int lat; bit rl;
      do_read(24'h008000, d1, lat, rl);
      do_read(24'h008010, d2, lat, rl);
      chk(d1 == fword(24'h008000) && d2 == fword(24'h008010), "R12 in-order responses", d2, fword(24'h008010));
   endtask

   task automatic t_sck();
      chk(SYS_MHZ <= 2 * HALF * 108, "R11 serial rate limit", SYS_MHZ / (2 * HALF), 108);
      chk(sck_bad == 0, "R11 SCK phase length", sck_bad, 0);
      chk(min_gap >= CSH, "R9 gap never short", min_gap, CSH);
   endtask

   initial begin
      t_reset();
      t_first();
      t_hit();
      t_edge();
      t_miss_mid();
      t_abort();
      t_order();
      repeat (300) @(negedge clk);
      t_sck();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule